// File: doc/BRIEF.md
# Scoreboarded Operand Fetch Stage

This block is the operand-fetch step of an in-order pipeline. Each cycle it may take one decoded instruction carrying two source register numbers, a destination register number and a flag that says whether the instruction writes a register. It either hands both operand values to the next stage or holds the instruction back. A table of busy bits, one per architectural register, records which registers still have a write in flight. The operand values come from an internal register file, or from a single forwarding path fed by the execute stage.

The writeback stage reaches the block through a direct port. A writeback always releases the busy bit of its register. It writes the register file only when the instruction was not squashed, so a squashed (poisoned) instruction still releases its register. Both effects are seen by the hazard check and the operand read in the same cycle. Busy bits are never cleared in bulk on a redirect. The forwarding path carries a register number and a value for one cycle. Only single-cycle arithmetic results use it; a load result reaches dependents through writeback.

Input and output each use a valid/ready handshake. A stalled cycle changes no state.

Top module: `sb_regread`

## Requirements
- R1: After reset every busy bit is clear, every register reads as zero, `out_valid` is 0 and `in_ready` is 1.
- R2: Accepting an instruction with `in_writes`=1 marks `in_dst` busy from the next cycle on. Register 0 is never marked busy.
- R3: A source numbered 0 yields the value zero. A writeback to register 0 has no effect.
- R4: When a source register is busy and the forwarding path does not carry that register number, `in_ready` is 0 and no output is produced.
- R5: When `fwd_valid`=1 and `fwd_idx` equals a source number, that source takes `fwd_data` in place of the register-file value, and a busy source is then accepted.
- R6: An instruction that writes a busy destination stalls (write-after-write), even when the forwarding path carries that destination's number.
- R7: A writeback with `wb_valid`=1 clears the busy bit of `wb_idx` and, when `wb_we`=1, writes `wb_data`. Both are visible to an instruction checked in that same cycle.
- R8: A writeback with `wb_valid`=1 and `wb_we`=0 clears the busy bit and leaves the register value unchanged.
- R9: When one cycle both releases and re-marks the same register, the register ends up busy.
- R10: While `out_valid`=1 and `out_ready`=0, the output fields hold and `in_ready` is 0. A stalled input changes no busy bit.
- R11: A busy bit stays set until a writeback names its register. Writebacks to other registers leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_src_a | input | IDX_W | First source register number |
| in_src_b | input | IDX_W | Second source register number |
| in_dst | input | IDX_W | Destination register number |
| in_writes | input | 1 | Instruction writes its destination |
| fwd_valid | input | 1 | Forwarded value present this cycle |
| fwd_idx | input | IDX_W | Register number of the forwarded value |
| fwd_data | input | DATA_W | Forwarded value |
| wb_valid | input | 1 | Writeback of a destination this cycle |
| wb_idx | input | IDX_W | Register number being written back |
| wb_we | input | 1 | Writeback carries an architectural write (0 = squashed) |
| wb_data | input | DATA_W | Writeback value |
| out_valid | output | 1 | Operands present for the next stage |
| out_ready | input | 1 | Next stage takes the operands |
| out_opnd_a | output | DATA_W | First operand value |
| out_opnd_b | output | DATA_W | Second operand value |
| out_dst | output | IDX_W | Destination register number passed on |
| out_writes | output | 1 | Destination write flag passed on |

## Verification
A writeback that releases a register can arrive in the same cycle as an instruction that wants that register, either as a source or as a destination. The bench drives exactly these collisions. In one case an instruction waits on a busy source while the writeback of that register lands in the same cycle. In another, a write-after-write stall is resolved by the writeback of its own destination. The bench then checks three things: the instruction is accepted in that very cycle, it carries the freshly written value, and the destination is busy again afterwards, which a later reader observes as a stall. A behavioural model run beside the design in long random phases produces further collisions of forwarding, writeback and backpressure, and every cycle is compared against it.

// File: rtl/sbrr_pkg.sv
package sbrr_pkg;

   // Where an operand value is taken from
   typedef enum logic [1:0] {
      OPND_RF   = 2'd0,
      OPND_FWD  = 2'd1,
      OPND_ZERO = 2'd2
   } opnd_src_e;

   localparam int unsigned SBRR_NUM_RD = 2;

   function automatic bit sbrr_is_pow2(input int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/sbrr_busy_table.sv
module sbrr_busy_table #(
   parameter int unsigned NUM_REGS = 32,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic [IDX_W-1:0]    set_idx,
   input  logic                clr_en,
   input  logic [IDX_W-1:0]    clr_idx,
   output logic [NUM_REGS-1:0] busy_q,
   output logic [NUM_REGS-1:0] busy_eff
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_row
      localparam logic [IDX_W-1:0] ROW = IDX_W'(i);
      logic set_hit;
      logic clr_hit;

      assign set_hit = set_en && (set_idx == ROW);
      assign clr_hit = clr_en && (clr_idx == ROW);

      if (ZERO_REG && (i == 0)) begin : g_tied
         always_ff @(posedge clk) begin
            busy_q[i] <= 1'b0;
         end
      end else begin : g_flop
         // a set in the same cycle as a clear keeps the bit
         always_ff @(posedge clk) begin
            if (!rst_n)       busy_q[i] <= 1'b0;
            else if (set_hit) busy_q[i] <= 1'b1;
            else if (clr_hit) busy_q[i] <= 1'b0;
         end
      end

      // a release arriving this cycle is already seen by the hazard check
      assign busy_eff[i] = busy_q[i] && !clr_hit;
   end

   AST_RR_BUSY_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_en |=> (($past(busy_q) & ~busy_q) == '0)); // R11

endmodule

// File: rtl/sbrr_regfile.sv
module sbrr_regfile #(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_RD   = 2,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
   output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
      localparam logic [IDX_W-1:0] ROW    = IDX_W'(r);
      localparam bit               LOCKED = ZERO_REG && (r == 0);
      logic hit;

      assign hit = wr_en && (wr_idx == ROW) && !LOCKED;

      always_ff @(posedge clk) begin
         if (!rst_n)   mem[r] <= '0;
         else if (hit) mem[r] <= wr_data;
      end
   end

   // read ports pass a same-cycle write straight through
   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      logic is_zero;
      logic pass;

      assign is_zero = ZERO_REG && (rd_idx[p] == '0);
      assign pass    = wr_en && (wr_idx == rd_idx[p]);

      always_comb begin
         if (is_zero)   rd_data[p] = '0;
         else if (pass) rd_data[p] = wr_data;
         else           rd_data[p] = mem[rd_idx[p]];
      end
   end

endmodule

// File: rtl/sbrr_src_check.sv
module sbrr_src_check
   import sbrr_pkg::*;
#(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned DATA_W   = 32,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [IDX_W-1:0]    src_idx,
   input  logic [NUM_REGS-1:0] busy_eff,
   input  logic                fwd_valid,
   input  logic [IDX_W-1:0]    fwd_idx,
   input  logic [DATA_W-1:0]   fwd_data,
   input  logic [DATA_W-1:0]   rf_data,
   output logic                blocked,
   output logic [DATA_W-1:0]   value
);

   opnd_src_e pick;
   logic      fwd_hit;
   logic      is_zero;

   assign fwd_hit = fwd_valid && (fwd_idx == src_idx);
   assign is_zero = ZERO_REG && (src_idx == '0);

   always_comb begin
      if (is_zero)      pick = OPND_ZERO;
      else if (fwd_hit) pick = OPND_FWD;
      else              pick = OPND_RF;
   end

   always_comb begin
      unique case (pick)
         OPND_ZERO: value = '0;
         OPND_FWD:  value = fwd_data;
         default:   value = rf_data;
      endcase
   end

   // a busy source may proceed only with a matching forwarded value
   assign blocked = busy_eff[src_idx] && !fwd_hit && !is_zero;

endmodule

// File: rtl/sb_regread.sv
module sb_regread
   import sbrr_pkg::*;
#(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned DATA_W   = 32,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [IDX_W-1:0]  in_src_a,
   input  logic [IDX_W-1:0]  in_src_b,
   input  logic [IDX_W-1:0]  in_dst,
   input  logic              in_writes,
   input  logic              fwd_valid,
   input  logic [IDX_W-1:0]  fwd_idx,
   input  logic [DATA_W-1:0] fwd_data,
   input  logic              wb_valid,
   input  logic [IDX_W-1:0]  wb_idx,
   input  logic              wb_we,
   input  logic [DATA_W-1:0] wb_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_opnd_a,
   output logic [DATA_W-1:0] out_opnd_b,
   output logic [IDX_W-1:0]  out_dst,
   output logic              out_writes
);

   localparam int unsigned NRD = SBRR_NUM_RD;

   if (!sbrr_is_pow2(NUM_REGS)) begin : g_bad_regs
      $error("sb_regread: NUM_REGS must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("sb_regread: DATA_W must be positive");
   end

   logic [NUM_REGS-1:0]          busy_q;
   logic [NUM_REGS-1:0]          busy_eff;
   logic [NRD-1:0][IDX_W-1:0]    src_idx;
   logic [NRD-1:0][DATA_W-1:0]   rf_val;
   logic [NRD-1:0][DATA_W-1:0]   opnd;
   logic [NRD-1:0]               src_blocked;
   logic                         dst_real;
   logic                         waw;
   logic                         stall;
   logic                         slot_free;
   logic                         fire;
   logic                         mark;

   assign src_idx[0] = in_src_a;
   assign src_idx[1] = in_src_b;

   sbrr_busy_table #(
      .NUM_REGS (NUM_REGS),
      .ZERO_REG (ZERO_REG)
   ) u_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (mark),
      .set_idx  (in_dst),
      .clr_en   (wb_valid),
      .clr_idx  (wb_idx),
      .busy_q   (busy_q),
      .busy_eff (busy_eff)
   );

   sbrr_regfile #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .NUM_RD   (NRD),
      .ZERO_REG (ZERO_REG)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wb_valid && wb_we),
      .wr_idx  (wb_idx),
      .wr_data (wb_data),
      .rd_idx  (src_idx),
      .rd_data (rf_val)
   );

   for (genvar s = 0; s < NRD; s++) begin : g_src
      sbrr_src_check #(
         .NUM_REGS (NUM_REGS),
         .DATA_W   (DATA_W),
         .ZERO_REG (ZERO_REG)
      ) u_chk (
         .src_idx   (src_idx[s]),
         .busy_eff  (busy_eff),
         .fwd_valid (fwd_valid),
         .fwd_idx   (fwd_idx),
         .fwd_data  (fwd_data),
         .rf_data   (rf_val[s]),
         .blocked   (src_blocked[s]),
         .value     (opnd[s])
      );
   end

   // write-after-write: forwarding never resolves a busy destination
   assign dst_real  = in_writes && !(ZERO_REG && (in_dst == '0));
   assign waw       = dst_real && busy_eff[in_dst];
   assign stall     = waw || (|src_blocked);
   assign slot_free = !out_valid || out_ready;
   assign in_ready  = !stall && slot_free;
   assign fire      = in_valid && in_ready;
   assign mark      = fire && dst_real;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_opnd_a <= '0;
         out_opnd_b <= '0;
         out_dst    <= '0;
         out_writes <= 1'b0;
      end else if (fire) begin
         out_valid  <= 1'b1;
         out_opnd_a <= opnd[0];
         out_opnd_b <= opnd[1];
         out_dst    <= in_dst;
         out_writes <= in_writes;
      end else if (out_ready) begin
         out_valid  <= 1'b0;
      end
   end

   AST_RR_MARK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_writes && (in_dst != '0)) |=> busy_q[$past(in_dst)]); // R2

   AST_RR_WAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_writes && (in_dst != '0) && busy_q[in_dst]
       && !(wb_valid && (wb_idx == in_dst))) |-> !in_ready); // R6

   AST_RR_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_opnd_a) && $stable(out_opnd_b)
                                     && $stable(out_dst))); // R10

   if (ZERO_REG) begin : g_zero_chk
      AST_RR_ZERO_OPND: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ready && (in_src_a == '0)) |=> (out_opnd_a == '0)); // R3
   end

endmodule

// File: tb/sb_regread_tb.sv
module sb_regread_tb;

   localparam int NR = 32;
   localparam int DW = 32;
   localparam int IW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          in_valid = 0, in_writes = 0, fwd_valid = 0, wb_valid = 0, wb_we = 0, out_ready = 1;
   logic [IW-1:0] in_src_a = 0, in_src_b = 0, in_dst = 0, fwd_idx = 0, wb_idx = 0;
   logic [DW-1:0] fwd_data = 0, wb_data = 0;
   logic          in_ready, out_valid, out_writes;
   logic [DW-1:0] out_opnd_a, out_opnd_b;
   logic [IW-1:0] out_dst;

   sb_regread u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_writes(in_writes),
      .fwd_valid(fwd_valid), .fwd_idx(fwd_idx), .fwd_data(fwd_data),
      .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_we(wb_we), .wb_data(wb_data),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_opnd_a(out_opnd_a), .out_opnd_b(out_opnd_b),
      .out_dst(out_dst), .out_writes(out_writes)
   );

   // behavioural reference state
   bit            m_busy [NR];
   logic [DW-1:0] m_reg  [NR];
   bit            m_ov;
   logic [DW-1:0] m_a, m_b;
   int            m_d;
   bit            m_w;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit eff_busy(input int i);
      if (i == 0) return 0;
      return m_busy[i] && !(wb_valid && int'(wb_idx) == i);
   endfunction

   function automatic bit fwd_for(input int i);
      return fwd_valid && int'(fwd_idx) == i;
   endfunction

   function automatic logic [DW-1:0] val_of(input int i);
      if (i == 0) return '0;
      if (fwd_for(i)) return fwd_data;
      if (wb_valid && wb_we && int'(wb_idx) == i) return wb_data;
      return m_reg[i];
   endfunction

   task automatic cyc(input bit iv, input int a, input int b, input int d, input bit w,
                      input bit fv, input int fi, input logic [DW-1:0] fd,
                      input bit wv, input int wi, input bit we, input logic [DW-1:0] wd,
                      input bit ordy, input string tag);
      bit stall, exp_rdy, fire;
      @(negedge clk);
      in_valid = iv; in_src_a = IW'(a); in_src_b = IW'(b); in_dst = IW'(d); in_writes = w;
      fwd_valid = fv; fwd_idx = IW'(fi); fwd_data = fd;
      wb_valid = wv; wb_idx = IW'(wi); wb_we = we; wb_data = wd;
      out_ready = ordy;
      #1;
      stall = (w && d != 0 && eff_busy(d)) || (eff_busy(a) && !fwd_for(a))
              || (eff_busy(b) && !fwd_for(b));
      exp_rdy = !stall && (!m_ov || ordy);
      chk(in_ready == exp_rdy, tag, "in_ready", DW'(in_ready), DW'(exp_rdy));
      chk(out_valid == m_ov, tag, "out_valid", DW'(out_valid), DW'(m_ov));
      if (m_ov) begin
         chk(out_opnd_a == m_a, tag, "operand a", out_opnd_a, m_a);
         chk(out_opnd_b == m_b, tag, "operand b", out_opnd_b, m_b);
         chk(int'(out_dst) == m_d && out_writes == m_w, tag, "dst/flag",
             {out_writes, DW'(out_dst)}, {m_w, DW'(m_d)});
      end
      fire = iv && exp_rdy;
      @(posedge clk);
      if (fire) begin
         m_ov = 1; m_a = val_of(a); m_b = val_of(b); m_d = d; m_w = w;
      end else if (ordy) begin
         m_ov = 0;
      end
      if (wv) begin
         m_busy[wi] = 0;
         if (we && wi != 0) m_reg[wi] = wd;
      end
      if (fire && w && d != 0) m_busy[d] = 1;
   endtask

   task automatic ins(input int a, input int b, input int d, input bit w, input string tag);
      cyc(1, a, b, d, w, 0, 0, 0, 0, 0, 0, 0, 1, tag);
   endtask

   task automatic wbk(input int wi, input bit we, input logic [DW-1:0] wd, input string tag);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, wi, we, wd, 1, tag);
   endtask

   initial begin
      for (int i = 0; i < NR; i++) begin m_busy[i] = 0; m_reg[i] = '0; end
      m_ov = 0; m_a = 0; m_b = 0; m_d = 0; m_w = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R1");
      ins(3, 4, 0, 0, "R1");                 // reset registers read zero
      wbk(5, 1, 32'h55, "R7");
      wbk(6, 1, 32'h66, "R7");
      wbk(0, 1, 32'hDEAD, "R3");             // ignored write to register 0
      ins(0, 5, 0, 0, "R3");
      ins(1, 2, 5, 1, "R2");                 // r5 busy
      repeat (3) ins(5, 6, 9, 1, "R4");      // stall on busy source
      cyc(1, 5, 6, 9, 1, 1, 5, 32'h1234, 0, 0, 0, 0, 1, "R5");
      repeat (2) cyc(1, 1, 1, 5, 1, 1, 5, 32'h4321, 0, 0, 0, 0, 1, "R6");
      cyc(1, 1, 1, 5, 1, 0, 0, 0, 1, 5, 1, 32'h77, 1, "R9"); // release and re-mark r5
      repeat (2) ins(5, 0, 0, 0, "R9");
      cyc(1, 5, 0, 0, 0, 0, 0, 0, 1, 5, 0, 32'hBAD, 1, "R8"); // squashed: keep 0x77
      ins(0, 0, 0, 0, "R8");
      repeat (2) ins(9, 0, 0, 0, "R4");
      cyc(1, 9, 0, 0, 0, 0, 0, 0, 1, 9, 1, 32'h99, 1, "R7"); // same-cycle write visible
      ins(0, 0, 7, 1, "R11");
      cyc(1, 7, 0, 0, 0, 0, 0, 0, 1, 8, 1, 32'h88, 1, "R11");
      ins(7, 0, 0, 0, "R11");
      cyc(1, 7, 8, 0, 0, 0, 0, 0, 1, 7, 1, 32'hAB, 1, "R11");
      cyc(1, 6, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
      repeat (3) cyc(1, 5, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
      cyc(1, 5, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
      ins(0, 0, 0, 0, "R10");

      for (int n = 0; n < 3000; n++) begin
         cyc($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 7),
             $urandom_range(0, 7), $urandom_range(0, 1),
             $urandom_range(0, 2) == 0, $urandom_range(0, 7), $urandom,
             $urandom_range(0, 2) == 0, $urandom_range(0, 7), $urandom_range(0, 3) != 0, $urandom,
             $urandom_range(0, 3) != 0, "R5");
      end
      for (int n = 0; n < 8; n++) wbk(n, 0, 0, "R11");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule